// File: doc/BRIEF.md
# Serial Line Activity Watchdog

This block watches the serial data lines of a scrambling and descrambling channel and reports when any of them goes quiet. Each watched line gets its own retriggerable timer. Any logic 1 seen on the line reloads the timer to its full window. If the window runs out with no logic 1, that line's monitor is marked as timed out. The window length, `TIMEOUT_CYCLES`, is given in clock cycles. For the field setting it equals 150 ms at the system clock, and a bench can pass a short value.

The block drives four registered flags:
- A scrambler-fail flag, active high.
- A descrambler-fail flag, active low. It covers both the descrambled data line and the received data line.
- A combined fault indicator.
- An inhibit indicator.

A fourth monitor serves the operate/inhibit mode input. In operate mode it watches the descrambled data line and its indicator stays dark. In inhibit mode its input is held low on purpose, so it times out and lights the inhibit indicator. All inputs pass through two-flop synchronizers before any logic uses them.

Top module: `line_activity_watch`

## Requirements
- R1: Each input passes through two flops. A line sampled high at a clock edge reloads its monitor at the second following edge. The indicators show the new monitor state one edge after that.
- R2: Any synchronized logic 1 reloads that line's counter to TIMEOUT_CYCLES. Each cycle with a synchronized 0 counts the counter down by one, stopping at zero. A monitor is timed out while its counter is zero.
- R3: `scr_fail_o` is 1 while the scrambler-line monitor is timed out and 0 while it is healthy.
- R4: `dscr_fail_n_o` is 0 while either the descrambled-line monitor or the received-line monitor is timed out. It is 1 while both are healthy.
- R5: `fault_led_o` is 1 exactly when at least one of the scrambler, descrambled or received monitors is timed out.
- R6: With `inhibit_mode_i` = 0 (operate), the fourth monitor is fed from the descrambled line, and `inhibit_led_o` is 0 whatever that monitor's state.
- R7: With `inhibit_mode_i` = 1 (inhibit), the fourth monitor's input is forced to 0. Once it has timed out, `inhibit_led_o` is 1.
- R8: Reset clears all counters to zero, so every monitor starts timed out. The reset values are `scr_fail_o`=1, `dscr_fail_n_o`=0, `fault_led_o`=1 and `inhibit_led_o`=0.
- R9: One-cycle pulses repeating every TIMEOUT_CYCLES cycles keep a monitor healthy. Pulses every TIMEOUT_CYCLES+1 cycles let it time out for one cycle before each reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scr_line_i | input | 1 | Scrambler data line (asynchronous) |
| dscr_line_i | input | 1 | Descrambled data line (asynchronous) |
| rcv_line_i | input | 1 | Received data line (asynchronous) |
| inhibit_mode_i | input | 1 | 0 = operate, 1 = inhibit (asynchronous) |
| scr_fail_o | output | 1 | Scrambler line failed, active high |
| dscr_fail_n_o | output | 1 | Descrambled or received line failed, active low |
| fault_led_o | output | 1 | Any data line failed |
| inhibit_led_o | output | 1 | Randomizer operation inhibited |

## Verification
The bench goes after the edge of the window. Pulses spaced exactly TIMEOUT_CYCLES apart must never produce a failure. Pulses one cycle further apart must produce a one-cycle failure before each reload, so a counter that is off by one in either direction shows up as a missing or spurious fail pulse.

It also kills one line at a time:
- Killing one line shows whether a design wired a monitor to the wrong flag.
- It shows whether a design got the active-low descrambler flag's polarity backwards.
- It shows whether a design left one of the three lines out of the fault indicator.

Switching between operate and inhibit modes shows whether a design lets the inhibit indicator light in operate mode, or fails to starve the fourth monitor in inhibit mode. A per-cycle reference model with the same synchronizer depth catches any extra or missing pipeline stage.

// File: rtl/lam_pkg.sv
package lam_pkg;

  // monitor slots; the descrambler flag combines DSCR and RCV
  localparam int NUM_MON  = 4;
  localparam int MON_SCR  = 0;
  localparam int MON_DSCR = 1;
  localparam int MON_RCV  = 2;
  localparam int MON_INH  = 3;

  typedef enum logic {
    MODE_OPERATE = 1'b0,
    MODE_INHIBIT = 1'b1
  } run_mode_e;

  // fault indicator rule: any data monitor timed out
  function automatic logic any_data_dead(input logic [NUM_MON-1:0] alive);
    return !(alive[MON_SCR] && alive[MON_DSCR] && alive[MON_RCV]);
  endfunction

endpackage

// File: rtl/lam_sync.sv
module lam_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // R1: the second stage only ever carries what the first stage held
  AST_SYNC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage2_q == $past(stage1_q)); // R1

endmodule

// File: rtl/lam_timer.sv
module lam_timer #(
  parameter int TIMEOUT_CYCLES = 30_000_000,
  parameter int CNT_W          = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic alive_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             expired;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                   input logic hit);
    if (hit)
      return LIMIT;
    else if (cur != '0)
      return cur - 1'b1;
    else
      return '0;
  endfunction

  assign cnt_next = next_count(cnt_q, hit_i);
  assign expired  = (cnt_q == '0);
  assign alive_o  = !expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> cnt_q == LIMIT); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R2
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !expired) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
  AST_STAY_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && expired) |=> !alive_o); // R2

endmodule

// File: rtl/lam_status.sv
module lam_status
  import lam_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] alive_i,
  input  run_mode_e          mode_i,
  output logic               scr_fail_o,
  output logic               dscr_fail_n_o,
  output logic               fault_led_o,
  output logic               inhibit_led_o
);

  logic scr_fail_d;
  logic dscr_ok_d;
  logic fault_d;
  logic inhibit_d;

  always_comb begin
    scr_fail_d = !alive_i[MON_SCR];
    dscr_ok_d  = alive_i[MON_DSCR] && alive_i[MON_RCV];
    fault_d    = any_data_dead(alive_i);
    inhibit_d  = (mode_i == MODE_INHIBIT) && !alive_i[MON_INH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_fail_o    <= 1'b1;
      dscr_fail_n_o <= 1'b0;
      fault_led_o   <= 1'b1;
      inhibit_led_o <= 1'b0;
    end else begin
      scr_fail_o    <= scr_fail_d;
      dscr_fail_n_o <= dscr_ok_d;
      fault_led_o   <= fault_d;
      inhibit_led_o <= inhibit_d;
    end
  end

  AST_SCR_FAIL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> scr_fail_o == !$past(alive_i[MON_SCR])); // R3
  AST_DSCR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dscr_fail_n_o == $past(alive_i[MON_DSCR] && alive_i[MON_RCV])); // R4
  AST_FAULT_WITH_SCR: assert property (@(posedge clk) disable iff (!rst_n)
    scr_fail_o |-> fault_led_o); // R5
  AST_FAULT_WITH_DSCR: assert property (@(posedge clk) disable iff (!rst_n)
    !dscr_fail_n_o |-> fault_led_o); // R5
  AST_INH_DARK_OPERATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_OPERATE) |=> !inhibit_led_o); // R6

endmodule

// File: rtl/line_activity_watch.sv
module line_activity_watch
  import lam_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scr_line_i,
  input  logic dscr_line_i,
  input  logic rcv_line_i,
  input  logic inhibit_mode_i,
  output logic scr_fail_o,
  output logic dscr_fail_n_o,
  output logic fault_led_o,
  output logic inhibit_led_o
);

  localparam int CNT_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int SYNC_W = NUM_MON;

  logic [SYNC_W-1:0]  raw_in;
  logic [SYNC_W-1:0]  sync_in;
  logic [NUM_MON-1:0] mon_hit;
  logic [NUM_MON-1:0] mon_alive;
  run_mode_e          mode_q;

  // slot MON_INH of the synchronizer carries the mode input
  assign raw_in[MON_SCR]  = scr_line_i;
  assign raw_in[MON_DSCR] = dscr_line_i;
  assign raw_in[MON_RCV]  = rcv_line_i;
  assign raw_in[MON_INH]  = inhibit_mode_i;

  lam_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  assign mode_q = run_mode_e'(sync_in[MON_INH]);

  // the inhibit monitor shadows the descrambled line, or is starved
  assign mon_hit[MON_SCR]  = sync_in[MON_SCR];
  assign mon_hit[MON_DSCR] = sync_in[MON_DSCR];
  assign mon_hit[MON_RCV]  = sync_in[MON_RCV];
  assign mon_hit[MON_INH]  = (mode_q == MODE_OPERATE) && sync_in[MON_DSCR];

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    lam_timer #(
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
      .CNT_W          (CNT_W)
    ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (mon_hit[g]),
      .alive_o (mon_alive[g])
    );
  end

  lam_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .alive_i       (mon_alive),
    .mode_i        (mode_q),
    .scr_fail_o    (scr_fail_o),
    .dscr_fail_n_o (dscr_fail_n_o),
    .fault_led_o   (fault_led_o),
    .inhibit_led_o (inhibit_led_o)
  );

  AST_INH_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_INHIBIT) |-> !mon_hit[MON_INH]); // R7
  AST_INH_LIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_INHIBIT) && !mon_alive[MON_INH]) |=> inhibit_led_o); // R7
  AST_LINE_REVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    mon_hit[MON_SCR] |=> ##1 !scr_fail_o); // R1

endmodule

// File: tb/test_line_activity_watch.sv
`timescale 1ns/1ps
module test_line_activity_watch;

  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scr = 1'b0, dscr = 1'b0, rcv = 1'b0, mode = 1'b0;
  logic scr_fail, dscr_fail_n, fault_led, inh_led;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  line_activity_watch #(.TIMEOUT_CYCLES(T)) i_line_activity_watch (
    .clk            (clk),
    .rst_n          (rst_n),
    .scr_line_i     (scr),
    .dscr_line_i    (dscr),
    .rcv_line_i     (rcv),
    .inhibit_mode_i (mode),
    .scr_fail_o     (scr_fail),
    .dscr_fail_n_o  (dscr_fail_n),
    .fault_led_o    (fault_led),
    .inhibit_led_o  (inh_led)
  );

  // behavioural reference: delay lines and plain integer countdowns
  bit  dly1[4], dly2[4];
  int  left[4];
  bit  e_scr, e_dfn, e_fault, e_inh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin dly1[i] = 0; dly2[i] = 0; left[i] = 0; end
      e_scr = 1; e_dfn = 0; e_fault = 1; e_inh = 0;
    end else begin
      bit feed[4];
      e_scr   = (left[0] == 0);
      e_dfn   = (left[1] > 0) && (left[2] > 0);
      e_fault = (left[0] == 0) || (left[1] == 0) || (left[2] == 0);
      e_inh   = dly2[3] && (left[3] == 0);
      feed[0] = dly2[0]; feed[1] = dly2[1]; feed[2] = dly2[2];
      feed[3] = !dly2[3] && dly2[1];
      for (int i = 0; i < 4; i++) begin
        if (feed[i]) left[i] = T;
        else if (left[i] > 0) left[i] = left[i] - 1;
      end
      for (int i = 0; i < 4; i++) dly2[i] = dly1[i];
      dly1[0] = scr; dly1[1] = dscr; dly1[2] = rcv; dly1[3] = mode;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3", "scr_fail_o", scr_fail, e_scr);
      check("R4", "dscr_fail_n_o", dscr_fail_n, e_dfn);
      check("R5", "fault_led_o", fault_led, e_fault);
      check("R6/R7", "inhibit_led_o", inh_led, e_inh);
    end
  end

  int scr_fail_seen;
  always @(negedge clk) if (scr_fail === 1'b1) scr_fail_seen++;

  // period 0 keeps the line low
  task automatic run(input int cycles, input int p_scr, input int p_dscr, input int p_rcv);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk); #1;
      scr  = (p_scr  != 0) && (c % p_scr  == 0);
      dscr = (p_dscr != 0) && (c % p_dscr == 0);
      rcv  = (p_rcv  != 0) && (c % p_rcv  == 0);
    end
  endtask

  task automatic settle_check(input string req, input logic s, input logic d,
                              input logic f, input logic ih);
    @(negedge clk);
    check(req, "scr_fail_o", scr_fail, s);
    check(req, "dscr_fail_n_o", dscr_fail_n, d);
    check(req, "fault_led_o", fault_led, f);
    check(req, "inhibit_led_o", inh_led, ih);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    settle_check("R8", 1'b1, 1'b0, 1'b1, 1'b0);

    run(60, 5, 5, 5);                         // R1 R2 all lines alive
    settle_check("R2", 1'b0, 1'b1, 1'b0, 1'b0);

    run(40, 0, 5, 5);                         // R3 scrambler line dead
    settle_check("R3", 1'b1, 1'b1, 1'b1, 1'b0);

    run(40, 5, 5, 0);                         // R4 received line dead
    settle_check("R4", 1'b0, 1'b0, 1'b1, 1'b0);

    run(40, 5, 0, 5);                         // R5 R6 descrambled line dead, operate
    settle_check("R6", 1'b0, 1'b0, 1'b1, 1'b0);

    mode = 1'b1;                              // R7 inhibit mode starves monitor
    run(40, 5, 5, 5);
    settle_check("R7", 1'b0, 1'b1, 1'b0, 1'b1);

    mode = 1'b0;                              // R6 back to operate
    run(40, 5, 5, 5);
    settle_check("R6", 1'b0, 1'b1, 1'b0, 1'b0);

    run(10, 5, 5, 5);
    scr_fail_seen = 0;
    run(200, T, 5, 5);                        // R9 period equal to window
    checks++;
    if (scr_fail_seen != 0) begin
      errors++;
      $display("FAIL R9 period T: actual %0d fail cycles expected 0", scr_fail_seen);
    end

    scr_fail_seen = 0;
    run(200, T + 1, 5, 5);                    // R9 period one past window
    checks++;
    if (scr_fail_seen == 0) begin
      errors++;
      $display("FAIL R9 period T+1: actual 0 fail cycles expected >0");
    end

    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule